// File: doc/BRIEF.md
# Register-Programmed Pulse-Width Modulator

This block is one pulse-width modulated output, set up through a small 32-bit register port. The port has a write strobe, a byte address, write data and read data. Software programs a high-time count and a cycle-length count, both in input clock cycles. It then sets a run bit in the control word. A free-running counter steps through the cycle, and the output is driven active while the counter is below the high-time count.

The control word holds several settings. One selects the output polarity. One is an active-high output mute. One gives a one-shot mode that stops after a single cycle. One restarts the counter. An end-of-cycle event sets a sticky flag, and that flag raises an interrupt line when it is unmasked. A reprogramming write takes effect at once and abandons the cycle in progress. Clearing the run bit drops the pin low on the following clock.

The read port is registered. The word at the address presented in one cycle appears on the read data in the next cycle. Reading has no side effects.

Top module: `pwmgen_top`

## Requirements
- R1: After synchronous reset, all three registers read 0, and `pwm_out` and `irq` are 0.
- R2: The high-time count is at byte address 0x4, the cycle-length count at 0x8 and the control word at 0xC. Any other address reads 0. `rd_data` shows the word at the address given one cycle earlier. Control bits 8 and 10 are stored and read back, but have no effect on the output.
- R3: While running with control bit9 = 0, the counter steps 0, 1, …, L−1 and then wraps, where L is the cycle-length count. `pwm_out` is 1 in the cycles where the counter is below the high-time count H. If H ≥ L, the output stays 1 for the whole cycle.
- R4: With control bit9 = 1, the output level is inverted, so H sets the low time of each cycle.
- R5: Control bit0 is the run bit. While it is 0, the counter is held at zero and `pwm_out` is 0 whatever bit9 holds. Clearing it forces `pwm_out` low on the clock after the write.
- R6: Control bit3 = 1 forces `pwm_out` to 0 while the counter keeps running.
- R7: When H and L are both 0, `pwm_out` stays 0, including when bit9 = 1.
- R8: A write to the high-time or cycle-length register restarts the counter from zero at that write.
- R9: Every wrap of the counter sets sticky flag bit6. `irq` is 1 exactly when bit6 and the interrupt mask bit5 are both 1. Writing 1 to bit6 clears it. If a wrap happens in the same cycle, the set wins.
- R10: With bit4 = 1, the block runs one full cycle. At the wrap it clears bit0 by itself, and the output then goes low.
- R11: Writing 1 to control bit7 zeroes the counter. The bit is not stored and always reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address of the register |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| pwm_out | output | 1 | Modulated output, registered |
| irq | output | 1 | Interrupt, flag AND mask, registered |

## Verification
The bound checker watches several properties on every cycle:
- the counter stays inside the programmed cycle,
- a length or high-time write, or the counter-restart bit, zeroes the counter on the next cycle,
- a cleared run bit, the mute bit or an all-zero setup keeps the pin low,
- a wrap sets the flag, and in one-shot mode it also clears the run bit,
- the interrupt line only rises while flag and mask are both set.

Only the bench's scenarios can show the following:
- the exact high and low pattern cycle by cycle for many random H, L and polarity settings,
- the addressing of the three registers and their readback,
- the restart of the pattern after a write partway through a cycle,
- the single cycle produced in one-shot mode.

// File: rtl/pwmgen_pkg.sv
package pwmgen_pkg;
  // byte offsets of the three registers
  localparam int OFF_HIGH = 4;
  localparam int OFF_LEN  = 8;
  localparam int OFF_CTL  = 12;
  // control word bit positions
  localparam int B_RUN    = 0;
  localparam int B_MUTE   = 3;
  localparam int B_ONE    = 4;
  localparam int B_MASK   = 5;
  localparam int B_FLAG   = 6;
  localparam int B_CLR    = 7;
  localparam int B_MEAS   = 8;
  localparam int B_INV    = 9;
  localparam int B_DZ     = 10;
  localparam int CTL_BITS = 11;
endpackage

// File: rtl/pwmgen_regfile.sv
module pwmgen_regfile
  import pwmgen_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wrap,
  output logic [DATA_W-1:0] high_q,
  output logic [DATA_W-1:0] len_q,
  output logic              run_q,
  output logic              mute_q,
  output logic              one_q,
  output logic              mask_q,
  output logic              flag_q,
  output logic              inv_q,
  output logic              restart,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_HIGH = ADDR_W'(OFF_HIGH);
  localparam logic [ADDR_W-1:0] A_LEN  = ADDR_W'(OFF_LEN);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFF_CTL);

  logic meas_q, dz_q;
  logic wr_high, wr_len, wr_ctl;
  logic run_n, flag_n, mask_n;
  logic [DATA_W-1:0] ctl_img, rd_n;

  assign wr_high = wr_en && (addr == A_HIGH);
  assign wr_len  = wr_en && (addr == A_LEN);
  assign wr_ctl  = wr_en && (addr == A_CTL);
  assign restart = wr_high || wr_len || (wr_ctl && wr_data[B_CLR]);

  always_comb begin
    if (wr_ctl)
      run_n = wr_data[B_RUN];
    else if (wrap && one_q)
      run_n = 1'b0;
    else
      run_n = run_q;
    mask_n = wr_ctl ? wr_data[B_MASK] : mask_q;
    flag_n = (flag_q && !(wr_ctl && wr_data[B_FLAG])) || wrap;
  end

  always_comb begin
    ctl_img         = '0;
    ctl_img[B_RUN]  = run_q;
    ctl_img[B_MUTE] = mute_q;
    ctl_img[B_ONE]  = one_q;
    ctl_img[B_MASK] = mask_q;
    ctl_img[B_FLAG] = flag_q;
    ctl_img[B_MEAS] = meas_q;
    ctl_img[B_INV]  = inv_q;
    ctl_img[B_DZ]   = dz_q;
  end

  always_comb begin
    unique case (addr)
      A_HIGH:  rd_n = high_q;
      A_LEN:   rd_n = len_q;
      A_CTL:   rd_n = ctl_img;
      default: rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      high_q  <= '0;
      len_q   <= '0;
      run_q   <= 1'b0;
      mute_q  <= 1'b0;
      one_q   <= 1'b0;
      mask_q  <= 1'b0;
      flag_q  <= 1'b0;
      meas_q  <= 1'b0;
      inv_q   <= 1'b0;
      dz_q    <= 1'b0;
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      if (wr_high) high_q <= wr_data;
      if (wr_len)  len_q  <= wr_data;
      if (wr_ctl) begin
        mute_q <= wr_data[B_MUTE];
        one_q  <= wr_data[B_ONE];
        meas_q <= wr_data[B_MEAS];
        inv_q  <= wr_data[B_INV];
        dz_q   <= wr_data[B_DZ];
      end
      run_q   <= run_n;
      mask_q  <= mask_n;
      flag_q  <= flag_n;
      rd_data <= rd_n;
      irq     <= flag_n && mask_n;
    end
  end
endmodule

// File: rtl/pwmgen_counter.sv
module pwmgen_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              restart,
  input  logic [DATA_W-1:0] len,
  output logic [DATA_W-1:0] cnt_q,
  output logic              wrap
);
  logic len_zero;
  assign len_zero = (len == '0);
  assign wrap = run && !len_zero && !restart && (cnt_q == len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (restart || !run || len_zero || wrap)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwmgen_outstage.sv
module pwmgen_outstage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              mute,
  input  logic              inv,
  input  logic [DATA_W-1:0] high,
  input  logic [DATA_W-1:0] len,
  input  logic [DATA_W-1:0] cnt,
  output logic              pwm_out
);
  logic all_zero, active, level;
  assign all_zero = (high == '0) && (len == '0);
  assign active   = (cnt < high);
  assign level    = run && !mute && !all_zero && (active ^ inv);

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b0;
    else     pwm_out <= level;
  end
endmodule

// File: rtl/pwmgen_top.sv
module pwmgen_top #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              pwm_out,
  output logic              irq
);
  logic [DATA_W-1:0] high_q, len_q, cnt_q;
  logic run_q, mute_q, one_q, mask_q, flag_q, inv_q, restart, wrap;

  pwmgen_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .wrap(wrap), .high_q(high_q), .len_q(len_q), .run_q(run_q),
    .mute_q(mute_q), .one_q(one_q), .mask_q(mask_q), .flag_q(flag_q),
    .inv_q(inv_q), .restart(restart), .rd_data(rd_data), .irq(irq)
  );

  pwmgen_counter #(.DATA_W(DATA_W)) cnt_i (
    .clk(clk), .rst(rst), .run(run_q), .restart(restart), .len(len_q),
    .cnt_q(cnt_q), .wrap(wrap)
  );

  pwmgen_outstage #(.DATA_W(DATA_W)) out_i (
    .clk(clk), .rst(rst), .run(run_q), .mute(mute_q), .inv(inv_q),
    .high(high_q), .len(len_q), .cnt(cnt_q), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/pwmgen_checker.sv
module pwmgen_checker
  import pwmgen_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              clr_bit,
  input logic              pwm_out,
  input logic              irq,
  input logic              run_q,
  input logic              mute_q,
  input logic              one_q,
  input logic              mask_q,
  input logic              flag_q,
  input logic              wrap,
  input logic [DATA_W-1:0] high_q,
  input logic [DATA_W-1:0] len_q,
  input logic [DATA_W-1:0] cnt_q
);
  localparam logic [ADDR_W-1:0] A_HIGH = ADDR_W'(OFF_HIGH);
  localparam logic [ADDR_W-1:0] A_LEN  = ADDR_W'(OFF_LEN);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFF_CTL);

  p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_q < len_q) || (cnt_q == '0));

  p_stop_low_r5: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> !pwm_out);

  p_mute_low_r6: assert property (@(posedge clk) disable iff (rst)
    mute_q |=> !pwm_out);

  p_zero_low_r7: assert property (@(posedge clk) disable iff (rst)
    (high_q == '0 && len_q == '0) |=> !pwm_out);

  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == A_HIGH || addr == A_LEN)) |=> (cnt_q == '0));

  p_flag_set_r9: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flag_q);

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (flag_q && mask_q));

  p_oneshot_r10: assert property (@(posedge clk) disable iff (rst)
    (wrap && one_q && !(wr_en && addr == A_CTL)) |=> !run_q);

  p_clr_bit_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CTL && clr_bit) |=> (cnt_q == '0));
endmodule

bind pwmgen_top pwmgen_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
  .clr_bit(wr_data[pwmgen_pkg::B_CLR]), .pwm_out(pwm_out), .irq(irq),
  .run_q(run_q), .mute_q(mute_q), .one_q(one_q), .mask_q(mask_q),
  .flag_q(flag_q), .wrap(wrap), .high_q(high_q), .len_q(len_q), .cnt_q(cnt_q)
);

// File: tb/pwmgen_tb.sv
`timescale 1ns/1ps
module pwmgen_top_tb_top;
  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          pwm_out, irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pwmgen_top #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .pwm_out(pwm_out), .irq(irq)
  );

  function automatic logic [DW-1:0] mk_ctl(bit run, bit mute, bit one, bit mask,
                                           bit flag, bit clr, bit meas, bit inv, bit dz);
    logic [DW-1:0] v = '0;
    v[0] = run; v[3] = mute; v[4] = one; v[5] = mask; v[6] = flag;
    v[7] = clr; v[8] = meas; v[9] = inv; v[10] = dz;
    return v;
  endfunction

  // expected level j cycles into a run whose counter started at zero
  function automatic bit exp_level(int unsigned j, int unsigned h, int unsigned l, bit inv);
    int unsigned ph;
    if (h == 0 && l == 0) return 1'b0;
    ph = (l == 0) ? 0 : (j % l);
    return (ph < h) ^ inv;
  endfunction

  task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(int a, logic [DW-1:0] d);
    wr_en = 1'b1; addr = AW'(a); wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic bus_read(int a, output logic [DW-1:0] d);
    addr = AW'(a);
    @(posedge clk);
    @(negedge clk);
    d = rd_data;
  endtask

  // called right after the write that started the pattern from counter zero
  task automatic run_check(int unsigned n, int unsigned h, int unsigned l, bit inv, string req);
    for (int unsigned j = 0; j < n; j++) begin
      @(posedge clk);
      @(negedge clk);
      check(pwm_out == exp_level(j, h, l, inv), req, pwm_out, exp_level(j, h, l, inv));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] rv;
    int unsigned seed_v;
    seed_v = $urandom(32'd20250517);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(pwm_out == 1'b0, "R1 pwm_out", pwm_out, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    bus_read(4, rv);  check(rv == 0, "R1 high reg", rv, 0);
    bus_read(8, rv);  check(rv == 0, "R1 len reg", rv, 0);
    bus_read(12, rv); check(rv == 0, "R1 ctl reg", rv, 0);

    // R2 map, readback, unused address, bits 8/10 inert
    bus_write(4, 32'hDEAD_BEEF);
    bus_write(8, 32'h1234_5678);
    bus_read(4, rv);  check(rv == 32'hDEAD_BEEF, "R2 high readback", rv, 32'hDEAD_BEEF);
    bus_read(8, rv);  check(rv == 32'h1234_5678, "R2 len readback", rv, 32'h1234_5678);
    bus_read(0, rv);  check(rv == 0, "R2 unmapped read", rv, 0);
    bus_write(12, mk_ctl(0,0,0,0,0,0,1,0,1));
    bus_read(12, rv);
    check(rv == mk_ctl(0,0,0,0,0,0,1,0,1), "R2 bits 8 and 10 stored", rv, mk_ctl(0,0,0,0,0,0,1,0,1));
    bus_write(4, 3);
    bus_write(8, 6);
    bus_write(12, mk_ctl(1,0,0,0,0,0,1,0,1));
    run_check(12, 3, 6, 0, "R2 bits 8 and 10 no effect");

    // R3 and R4 random patterns
    for (int k = 0; k < 40; k++) begin
      int unsigned h, l;
      bit iv;
      l  = 1 + ($urandom % 12);
      h  = $urandom % 15;
      iv = ($urandom % 2) == 1;
      bus_write(12, mk_ctl(0,0,0,0,1,0,0,iv,0));
      bus_write(4, h);
      bus_write(8, l);
      bus_write(12, mk_ctl(1,0,0,0,0,0,0,iv,0));
      run_check(3 * l + 2, h, l, iv, iv ? "R4 inverted pattern" : "R3 normal pattern");
    end

    // R3 high >= length stays active
    bus_write(12, 0);
    bus_write(4, 9);
    bus_write(8, 5);
    bus_write(12, mk_ctl(1,0,0,0,0,0,0,0,0));
    run_check(12, 9, 5, 0, "R3 high beyond length");

    // R7 both zero, with inversion
    bus_write(12, 0);
    bus_write(4, 0);
    bus_write(8, 0);
    bus_write(12, mk_ctl(1,0,0,0,0,0,0,1,0));
    run_check(8, 0, 0, 1, "R7 all zero low");

    // R5 disable with inversion: high before, low the clock after
    bus_write(12, 0);
    bus_write(4, 0);
    bus_write(8, 4);
    bus_write(12, mk_ctl(1,0,0,0,0,0,0,1,0));
    run_check(6, 0, 4, 1, "R5 inverted running");
    bus_write(12, mk_ctl(0,0,0,0,0,0,0,1,0));
    check(pwm_out == 1'b1, "R5 level before stop takes effect", pwm_out, 1);
    @(posedge clk); @(negedge clk);
    check(pwm_out == 1'b0, "R5 stop forces low", pwm_out, 0);
    repeat (5) @(negedge clk);
    check(pwm_out == 1'b0, "R5 stays low", pwm_out, 0);

    // R6 mute
    bus_write(4, 4);
    bus_write(8, 4);
    bus_write(12, mk_ctl(1,1,0,0,0,0,0,0,0));
    for (int j = 0; j < 6; j++) begin
      @(posedge clk); @(negedge clk);
      check(pwm_out == 1'b0, "R6 muted", pwm_out, 0);
    end
    bus_write(12, mk_ctl(1,0,0,0,0,0,0,0,0));
    @(posedge clk); @(negedge clk);
    check(pwm_out == 1'b1, "R6 unmuted", pwm_out, 1);

    // R8 mid-cycle reprogram restarts
    bus_write(12, 0);
    bus_write(4, 3);
    bus_write(8, 8);
    bus_write(12, mk_ctl(1,0,0,0,0,0,0,0,0));
    run_check(5, 3, 8, 0, "R8 before rewrite");
    bus_write(4, 3);
    run_check(10, 3, 8, 0, "R8 high rewrite restarts");
    repeat (2) @(negedge clk);
    bus_write(8, 8);
    run_check(10, 3, 8, 0, "R8 length rewrite restarts");

    // R11 counter restart bit
    repeat (3) @(negedge clk);
    bus_write(12, mk_ctl(1,0,0,0,0,1,0,0,0));
    run_check(10, 3, 8, 0, "R11 clear bit restarts");
    bus_read(12, rv);
    check(rv[7] == 1'b0, "R11 clear bit reads 0", rv[7], 0);

    // R10 one-shot and R9 flag/irq
    bus_write(12, mk_ctl(0,0,0,0,1,0,0,0,0));
    check(irq == 1'b0, "R9 irq low, mask clear", irq, 0);
    bus_write(4, 2);
    bus_write(8, 5);
    bus_write(12, mk_ctl(1,0,1,1,0,0,0,0,0));
    check(irq == 1'b0, "R9 irq low before wrap", irq, 0);
    for (int unsigned j = 0; j < 9; j++) begin
      @(posedge clk); @(negedge clk);
      check(pwm_out == ((j < 5) ? exp_level(j, 2, 5, 0) : 1'b0), "R10 one-shot pattern",
            pwm_out, (j < 5) ? exp_level(j, 2, 5, 0) : 1'b0);
    end
    check(irq == 1'b1, "R9 irq after wrap", irq, 1);
    bus_read(12, rv);
    check(rv[0] == 1'b0, "R10 run bit cleared", rv[0], 0);
    check(rv[6] == 1'b1, "R9 flag set", rv[6], 1);
    bus_write(12, mk_ctl(0,0,1,0,0,0,0,0,0));
    check(irq == 1'b0, "R9 mask clear drops irq", irq, 0);
    bus_read(12, rv);
    check(rv[6] == 1'b1, "R9 flag sticky", rv[6], 1);
    bus_write(12, mk_ctl(0,0,0,1,1,0,0,0,0));
    check(irq == 1'b0, "R9 irq after clear", irq, 0);
    bus_read(12, rv);
    check(rv[6] == 1'b0, "R9 flag cleared by 1", rv[6], 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule